// File: doc/BRIEF.md
# AFSK Tone Modulator with Zero Insertion

This block turns a stream of bytes into 8-bit unsigned audio samples. The samples carry two-tone frequency-shift keying at 1200 bit/s, with a 1200 Hz mark tone and a 2200 Hz space tone, at a 9600 Hz sample rate. Bytes arrive on a valid/ready handshake and are serialised least significant bit first. Line coding is NRZI: a zero bit swaps the tone and a one bit keeps it. A sideband bit marks a byte as a flag. Flag bytes are sent without zero insertion. For all other bytes, a zero is inserted after every run of five ones.

Tone synthesis uses a 9-bit phase accumulator. Its output addresses a quarter-wave sine table of 128 entries, with index mirroring and half-wave inversion. The accumulator is never cleared when the tone changes, so the waveform stays phase-continuous. One sample is produced for each pulse of a sample-rate strobe. Between frames the output rests at mid-scale. Framing, preamble timing and the converter are handled elsewhere.

Top module: `afsk_tx`

## Requirements
- R1: After reset, and on every strobe that finds no bit to send, `sample_out` is 128. After reset, `busy` is 0 and `in_ready` is 1.
- R2: Each byte is sent least significant bit first. Each bit, stuffed or not, occupies exactly 8 consecutive strobes, and back-to-back bits follow with no gap.
- R3: At the first strobe of a bit, a 0 swaps the active tone between mark and space, and a 1 keeps it. The tone never changes inside a bit.
- R4: The phase advances by 64 per strobe for mark and by 117 per strobe for space, modulo 512. After reset the phase is 0 and the tone is mark. Neither is cleared at tone changes or across idle gaps.
- R5: The quarter table entry k (0..127) equals floor(127.5 + 127.5·sin(2πk/512) + 0.5).
- R6: The emitted sample is formed from the advanced phase p. Let i = p mod 256, and use 255−i when i ≥ 128. The sample is table[i] when p < 256 and 255−table[i] otherwise. First-half samples are therefore ≥ 128, and second-half samples are ≤ 127.
- R7: For bytes with `in_flag` = 0, a 0 bit is inserted after five consecutive 1 bits, and the run count restarts. Runs carry across byte boundaries. A pending inserted 0 goes out before the next byte's bits.
- R8: While a byte with `in_flag` = 1 is sent, no zero is inserted and the run of ones is cleared after each of its bits.
- R9: `in_ready` is 1 exactly when no bits of an accepted byte remain to be sent. `busy` stays 1 until the strobe that emits the last sample of the last bit, and is 0 afterwards.
- R10: `sample_out` changes only on the clock edge that samples a strobe, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle sample-rate strobe |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send, least significant bit first |
| in_flag | input | 1 | Byte is a flag; no zero insertion |
| in_ready | output | 1 | Byte can be accepted |
| sample_out | output | 8 | Unsigned audio sample |
| busy | output | 1 | Bits still pending or in flight |

## Verification
The bench targets runs of ones: within one byte, spanning two bytes, and directly before a flag. A design that counted badly would insert zeros in the wrong place or inside flags, and every following tone would then swap at the wrong bit. Long all-zero bytes and idle gaps check that the phase is never reset. A design that restarted the phase at tone changes or frame starts would show a jump in the sample sequence. Every accumulator value the traffic reaches is compared against a lookup modelled from the mirroring rules, which exposes an off-by-one mirror or a missing half-wave inversion. The busy-to-idle transition is checked strobe by strobe, so a design that dropped busy early or emitted a short final bit would mismatch.

// File: rtl/afsk_tx_pkg.sv
package afsk_tx_pkg;

    localparam int PHASE_STEPS = 512;
    localparam int PHASE_W     = $clog2(PHASE_STEPS);
    localparam int QUARTER     = PHASE_STEPS / 4;
    localparam int QIDX_W      = $clog2(QUARTER);
    localparam int SAMPLE_HZ   = 9600;
    localparam int BIT_HZ      = 1200;
    localparam int MARK_HZ     = 1200;
    localparam int SPACE_HZ    = 2200;
    localparam int SPB         = SAMPLE_HZ / BIT_HZ;
    localparam int CNT_W       = $clog2(SPB);
    localparam int MARK_INC    = (PHASE_STEPS * MARK_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ;
    localparam int SPACE_INC   = (PHASE_STEPS * SPACE_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [7:0]         sample_t;

    localparam sample_t MID_SCALE = 8'd128;

    typedef enum logic {
        TONE_MARK  = 1'b0,
        TONE_SPACE = 1'b1
    } tone_e;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_slot_t;

    function automatic phase_t inc_of(tone_e t);
        return (t == TONE_SPACE) ? phase_t'(SPACE_INC) : phase_t'(MARK_INC);
    endfunction

    function automatic tone_e swap_tone(tone_e t);
        return (t == TONE_MARK) ? TONE_SPACE : TONE_MARK;
    endfunction

    function automatic sample_t quarter_value(int k);
        real ang;
        ang = 2.0 * 3.14159265358979 * real'(k) / real'(PHASE_STEPS);
        return sample_t'($rtoi(127.5 + 127.5 * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/afsk_sine_lut.sv
module afsk_sine_lut
    import afsk_tx_pkg::*;
(
    input  phase_t  phase,
    output sample_t sample
);
    sample_t             rom [QUARTER];
    logic [QIDX_W:0]     low;
    logic [QIDX_W-1:0]   idx;
    sample_t             qval;

    for (genvar k = 0; k < QUARTER; k++) begin : g_rom
        localparam sample_t VAL = quarter_value(k);
        assign rom[k] = VAL;
    end

    always_comb begin
        low    = phase[QIDX_W:0];
        idx    = low[QIDX_W] ? ~low[QIDX_W-1:0] : low[QIDX_W-1:0];
        qval   = rom[idx];
        sample = phase[PHASE_W-1] ? ~qval : qval;
    end

    // R6: first half-wave at or above mid-scale, second half below
    always_comb begin
        if (!$isunknown(phase)) begin
            a_r6_half_sign: assert (sample[7] == ~phase[PHASE_W-1]);
        end
    end

endmodule

// File: rtl/afsk_bit_feeder.sv
module afsk_bit_feeder
    import afsk_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_flag,
    output logic              in_ready,
    input  logic              take,
    output bit_slot_t         slot
);
    localparam int LW = $clog2(BYTE_W + 1);
    localparam int OW = $clog2(STUFF_RUN + 1);

    logic [BYTE_W-1:0] shreg_q;
    logic [LW-1:0]     left_q;
    logic              flag_q;
    logic [OW-1:0]     ones_q;
    logic              stuff_due;

    always_comb begin
        stuff_due  = (ones_q == OW'(STUFF_RUN));
        in_ready   = (left_q == '0);
        slot.valid = stuff_due || (left_q != '0);
        slot.value = stuff_due ? 1'b0 : shreg_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
            flag_q  <= 1'b0;
            ones_q  <= '0;
        end else begin
            if (in_valid && in_ready) begin
                shreg_q <= in_data;
                left_q  <= LW'(BYTE_W);
                flag_q  <= in_flag;
            end
            if (take) begin
                if (stuff_due) begin
                    ones_q <= '0;
                end else begin
                    shreg_q <= shreg_q >> 1;
                    left_q  <= left_q - 1'b1;
                    if (flag_q || !shreg_q[0])
                        ones_q <= '0;
                    else
                        ones_q <= ones_q + 1'b1;
                end
            end
        end
    end

    a_r7_run_cap: assert property (@(posedge clk) disable iff (rst)
        ones_q <= OW'(STUFF_RUN));

    a_r7_stuff_resets: assert property (@(posedge clk) disable iff (rst)
        take && stuff_due |=> ones_q == '0);

    a_r8_flag_clears: assert property (@(posedge clk) disable iff (rst)
        take && flag_q && !stuff_due |=> ones_q == '0);

    a_r9_ready_pending: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> slot.valid);

endmodule

// File: rtl/afsk_tone_phase.sv
module afsk_tone_phase
    import afsk_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  logic   start,
    input  logic   bit_val,
    output phase_t phase_next
);
    phase_t phase_q;
    tone_e  tone_q;
    tone_e  tone_use;

    always_comb begin
        tone_use   = (start && !bit_val) ? swap_tone(tone_q) : tone_q;
        phase_next = phase_q + inc_of(tone_use);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            tone_q  <= TONE_MARK;
        end else if (advance) begin
            phase_q <= phase_next;
            tone_q  <= tone_use;
        end
    end

    a_r3_zero_swaps: assert property (@(posedge clk) disable iff (rst)
        advance && start && !bit_val |=> tone_q != $past(tone_q));

    a_r3_one_keeps: assert property (@(posedge clk) disable iff (rst)
        advance && start && bit_val |=> $stable(tone_q));

    a_r3_steady_in_bit: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(tone_q));

    a_r4_phase_idle: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(phase_q));

endmodule

// File: rtl/afsk_tx.sv
module afsk_tx
    import afsk_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_tick,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_flag,
    output logic              in_ready,
    output logic [7:0]        sample_out,
    output logic              busy
);
    bit_slot_t        slot;
    logic             in_slot;
    logic [CNT_W-1:0] smp_cnt;
    logic             fetch;
    logic             emit;
    phase_t           phase_next;
    sample_t          lut_out;

    always_comb begin
        fetch = sample_tick && !in_slot && slot.valid;
        emit  = sample_tick && (in_slot || fetch);
        busy  = in_slot || slot.valid;
    end

    afsk_bit_feeder #(
        .BYTE_W    (BYTE_W),
        .STUFF_RUN (STUFF_RUN)
    ) u_feed (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_flag  (in_flag),
        .in_ready (in_ready),
        .take     (fetch),
        .slot     (slot)
    );

    afsk_tone_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .advance    (emit),
        .start      (fetch),
        .bit_val    (slot.value),
        .phase_next (phase_next)
    );

    afsk_sine_lut u_lut (
        .phase  (phase_next),
        .sample (lut_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_slot    <= 1'b0;
            smp_cnt    <= '0;
            sample_out <= MID_SCALE;
        end else if (sample_tick) begin
            sample_out <= emit ? lut_out : MID_SCALE;
            if (fetch) begin
                in_slot <= 1'b1;
                smp_cnt <= CNT_W'(1);
            end else if (in_slot) begin
                if (smp_cnt == CNT_W'(SPB - 1)) begin
                    in_slot <= 1'b0;
                    smp_cnt <= '0;
                end else begin
                    smp_cnt <= smp_cnt + 1'b1;
                end
            end
        end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_tick) |-> $stable(sample_out));

    a_r1_idle_mid: assert property (@(posedge clk) disable iff (rst)
        $past(sample_tick) && !$past(busy) |-> sample_out == MID_SCALE);

    a_r2_no_refetch: assert property (@(posedge clk) disable iff (rst)
        in_slot && smp_cnt != CNT_W'(SPB - 1) |-> !fetch && busy);

endmodule

// File: tb/afsk_tx_tb.sv
`timescale 1ns/1ps
module afsk_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_flag = 1'b0;
    logic       in_ready;
    logic [7:0] sample_out;
    logic       busy;

    always #2.5 clk = ~clk;

    afsk_tx u_dut (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_flag     (in_flag),
        .in_ready    (in_ready),
        .sample_out  (sample_out),
        .busy        (busy)
    );

    typedef struct {
        int v;
        int tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   mon_on = 0;
    bit   timed_out = 0;

    int   m_phase = 0;
    bit   m_space = 0;
    int   m_ones = 0;

    function automatic string tag_name(int t);
        case (t)
            7:       return "R7";
            8:       return "R8";
            default: return "R2/R3/R4/R5/R6";
        endcase
    endfunction

    function automatic int q_ref(int k);
        return $rtoi(127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 512.0) + 0.5);
    endfunction

    function automatic int smp_ref(int p);
        int lo;
        int v;
        lo = p % 256;
        if (lo >= 128) lo = 255 - lo;
        v = q_ref(lo);
        return (p >= 256) ? 255 - v : v;
    endfunction

    task automatic push_bit(bit b, int tag);
        int inc;
        if (!b) m_space = !m_space;
        inc = m_space ? 117 : 64;
        for (int s = 0; s < 8; s++) begin
            exp_t e;
            m_phase = (m_phase + inc) % 512;
            e.v = smp_ref(m_phase);
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic send(logic [7:0] d, bit f);
        for (int i = 0; i < 8; i++) begin
            push_bit(d[i], f ? 8 : 2);
            if (f) m_ones = 0;
            else if (d[i]) begin
                m_ones++;
                if (m_ones == 5) begin
                    push_bit(1'b0, 7);
                    m_ones = 0;
                end
            end else m_ones = 0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_flag  = f;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // tick generator and scoreboard monitor
    initial begin
        int  last;
        bit  pre_busy;
        exp_t e;
        last = 128;
        wait (mon_on);
        forever begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(sample_out == last[7:0], "R10", sample_out, last);
            end
            sample_tick = 1'b1;
            pre_busy = busy;
            @(negedge clk);
            sample_tick = 1'b0;
            if (pre_busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(sample_out == e.v[7:0], tag_name(e.tag), sample_out, e.v);
                end
            end else begin
                check(exp_q.size() == 0, "R9", exp_q.size(), 0);
                check(sample_out == 8'd128, "R1", sample_out, 128);
            end
            last = sample_out;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sample_out == 8'd128, "R1", sample_out, 128);
        check(busy == 1'b0, "R1", busy, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        fork
            begin
                // flags without stuffing, including a run of eight ones (R8)
                send(8'h7E, 1'b1);
                send(8'hFF, 1'b1);
                // all zeros: tone swaps every bit (R3, R4)
                send(8'h00, 1'b0);
                // asymmetric pattern for bit order (R2)
                send(8'h35, 1'b0);
                send(8'hA1, 1'b0);
                // ones runs within and across bytes (R7)
                send(8'hFF, 1'b0);
                send(8'hFF, 1'b0);
                send(8'h7E, 1'b0);
                // data ending in five ones right before a flag (R7, R8)
                send(8'hF8, 1'b0);
                send(8'h7E, 1'b1);
                drain();
                check(busy == 1'b0, "R9", busy, 0);
                check(in_ready == 1'b1, "R9", in_ready, 1);
                check(sample_out == 8'd128, "R1", sample_out, 128);
                // phase continuity across an idle gap (R4)
                send(8'h0F, 1'b0);
                send(8'hC3, 1'b0);
                send(8'h3E, 1'b0);
                send(8'h55, 1'b1);
                drain();
                check(busy == 1'b0, "R9", busy, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule